// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel sample pairs. The stream arrives on three lines: a bit clock, a word-select line and a data line. Each word is two's complement and sent MSB first. In every frame the left word comes before the right word. The receiver handles five framings: left-justified, I2S, right-justified with a selectable word length, a pulse-framed DSP format, and a packed format with 16 bit slots per channel. When a frame is complete, it presents a 24-bit left and right sample together and pulses a valid strobe for one cycle.

All three serial lines are sampled on the fast system clock, and bit-clock edges are detected in that domain. The DSP format samples data on the falling bit-clock edge. All other formats sample on the rising edge.

The format comes from a 2-bit register field when that field is non-zero. Otherwise it comes from a 2-bit pin field. A system integrator can therefore fix the format in hardware and still let firmware override it.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release, `left_out` and `right_out` are zero and `pair_valid` is low.
- R2: The effective format is `reg_fmt` when `reg_fmt` is non-zero, and `pin_fmt` otherwise. The codes are 0 right-justified, 1 I2S, 2 left-justified and 3 DSP.
- R3: In left-justified mode, word-select high marks the left channel. The MSB is the bit sampled on the same rising bit-clock edge that first shows the new word-select level.
- R4: In I2S mode, word-select low marks the left channel. The MSB is sampled one rising bit-clock edge after the edge that shows the new level.
- R5: In right-justified mode, counting the edge that shows the new word-select level as slot 0, capture starts at slot 8 when `rj_len` is 0 or 3, at slot 12 when it is 1, and at slot 16 when it is 2. Word-select high marks the left channel.
- R6: In DSP mode, data is sampled on falling bit-clock edges. A falling edge that sees word-select rise to high starts a word. The MSB is the first slot sampled low after that pulse. After synchronisation, the first pulse starts a left word, and the channel alternates on each pulse after that.
- R7: With `pack_en` high, left-justified and right-justified modes both start capture at slot 0, whatever `rj_len` is. In I2S and DSP modes `pack_en` has no effect.
- R8: A word holds at most 24 captured bits, and bits after the 24th are dropped. A shorter word is left-aligned. Slots after its LSB are captured as they arrive, so a sender that wants zero low bits must drive zeros there.
- R9: `pair_valid` is a one-cycle pulse. It rises on the second rising clock edge after the sample edge that begins the following left word (a word-select change to the left level, or a DSP pulse). `left_out` and `right_out` change only in that cycle.
- R10: After reset, or after any change on `pin_fmt`, `reg_fmt`, `rj_len` or `pack_en`, the first sample edge only records word-select. No pair is emitted until a left word that began at a detected start has been followed by a complete right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Word-select / frame line |
| sdata | input | 1 | Serial data, MSB first |
| pin_fmt | input | 2 | Format from strap pins |
| reg_fmt | input | 2 | Format from register; non-zero overrides pins |
| rj_len | input | 2 | Right-justified word length: 0/3 = 24, 1 = 20, 2 = 16 |
| pack_en | input | 1 | Packed framing (16 slots per channel) for LJ/RJ |
| left_out | output | SW | Left sample, two's complement |
| right_out | output | SW | Right sample, two's complement |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench uses the default parameters: 24-bit samples, a 32-slot right-justified reference half-frame, and a 6-bit slot counter. With these values the right-justified offsets of 8, 12 and 16 all fall inside a 64-slot frame. Packed 16-slot halves and DSP halves of 30 and 32 slots are also within reach, and 28-bit words overrun the 24-bit capacity. The bench switches the configuration between streams, so the resynchronisation rule and the partial-frame drop are both exercised each time. Every expected pair is tied to an exact clock cycle, so any latency slip is caught as well as any data error.

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx #(
  parameter int SW    = 24,
  parameter int SLOTS = 32,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  input  logic [1:0]    pin_fmt,
  input  logic [1:0]    reg_fmt,
  input  logic [1:0]    rj_len,
  input  logic          pack_en,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out,
  output logic          pair_valid
);
  localparam int KW = $clog2(SW + 1);
  localparam logic [1:0] F_RJ = 2'd0, F_I2S = 2'd1, F_LJ = 2'd2, F_DSP = 2'd3;
  localparam logic [CW-1:0] CMAX  = '1;
  localparam logic [CW-1:0] OFS_A = CW'(SLOTS - SW);
  localparam logic [CW-1:0] OFS_B = CW'(SLOTS - SW + 4);
  localparam logic [CW-1:0] OFS_C = CW'(SLOTS - SW + 8);

  logic [1:0]    fmt;
  logic [6:0]    cfg, cfg_q;
  logic          s_bclk, s_bclk_d, s_lr, s_sd;
  logic          primed, synced, lr_prev, half_right, have_left;
  logic [CW-1:0] cnt, idx, first_idx;
  logic [KW-1:0] k, base_k;
  logic [SW-1:0] acc, base_acc, acc_n, lhold;
  logic          dsp, ev, start_ev, take, fin;

  assign fmt = (reg_fmt != 2'd0) ? reg_fmt : pin_fmt;
  assign cfg = {pin_fmt, reg_fmt, rj_len, pack_en};
  assign dsp = (fmt == F_DSP);
  assign ev  = dsp ? (s_bclk_d & ~s_bclk) : (s_bclk & ~s_bclk_d);
  assign start_ev = ev & primed & (dsp ? (s_lr & ~lr_prev) : (s_lr ^ lr_prev));
  assign fin      = start_ev & synced;
  assign idx      = start_ev ? '0 : cnt;
  assign base_k   = start_ev ? '0 : k;
  assign base_acc = start_ev ? '0 : acc;

  always_comb begin
    case (fmt)
      F_I2S:   first_idx = CW'(1);
      F_RJ:    first_idx = pack_en ? '0 :
                           (rj_len == 2'd1) ? OFS_B :
                           (rj_len == 2'd2) ? OFS_C : OFS_A;
      default: first_idx = '0;
    endcase
  end

  assign take = ev & (synced | start_ev) & (base_k < KW'(SW)) &
                (dsp ? ~s_lr : (idx >= first_idx));

  always_comb begin
    acc_n = base_acc;
    if (take) acc_n[SW-1-int'(base_k)] = s_sd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; s_bclk <= 1'b0; s_bclk_d <= 1'b0; s_lr <= 1'b0; s_sd <= 1'b0;
      primed <= 1'b0; synced <= 1'b0; lr_prev <= 1'b0; half_right <= 1'b0;
      have_left <= 1'b0; cnt <= '0; k <= '0; acc <= '0; lhold <= '0;
      left_out <= '0; right_out <= '0; pair_valid <= 1'b0;
    end else begin
      cfg_q <= cfg;
      s_bclk <= bclk; s_bclk_d <= s_bclk; s_lr <= lrclk; s_sd <= sdata;
      pair_valid <= 1'b0;
      if (cfg != cfg_q) begin
        primed <= 1'b0; synced <= 1'b0; have_left <= 1'b0;
      end else if (ev) begin
        primed  <= 1'b1;
        lr_prev <= s_lr;
        if (start_ev) begin
          synced     <= 1'b1;
          half_right <= dsp ? (synced & ~half_right) :
                        ((fmt == F_I2S) ? s_lr : ~s_lr);
        end
        if (fin) begin
          if (!half_right) begin
            lhold <= acc; have_left <= 1'b1;
          end else if (have_left) begin
            left_out <= lhold; right_out <= acc;
            pair_valid <= 1'b1; have_left <= 1'b0;
          end
        end
        acc <= acc_n;
        k   <= base_k + KW'(take);
        cnt <= (idx == CMAX) ? idx : idx + CW'(1);
      end
    end
  end
endmodule

module serial_audio_rx_chk #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk,
  input logic [1:0]    pin_fmt,
  input logic [1:0]    reg_fmt,
  input logic [1:0]    rj_len,
  input logic          pack_en,
  input logic [SW-1:0] left_out,
  input logic [SW-1:0] right_out,
  input logic          pair_valid
);
  logic [6:0] cfg;
  assign cfg = {pin_fmt, reg_fmt, rj_len, pack_en};

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pair_valid && left_out == '0 && right_out == '0));

  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  // R9
  output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));

  // R9
  strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(bclk, 2) != $past(bclk, 3)));

  // R10
  cfg_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |=> !pair_valid);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .pin_fmt(pin_fmt), .reg_fmt(reg_fmt),
  .rj_len(rj_len), .pack_en(pack_en), .left_out(left_out), .right_out(right_out),
  .pair_valid(pair_valid)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
  localparam int CLK_NS = 10;
  localparam int H = 2;

  typedef struct { int cyc; logic [23:0] l; logic [23:0] r; string tag; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0] pin_fmt = 2'd0, reg_fmt = 2'd0, rj_len = 2'd0;
  logic pack_en = 1'b0;
  logic [23:0] left_out, right_out;
  logic pair_valid;

  int pcyc = 0, vectors = 0, miscompares = 0;
  bit armed = 0, done = 0;
  exp_t q[$];
  int b_fmt = 2;
  bit b_pack = 0, pend = 0;
  logic [23:0] pl, pr;
  string ptag;
  int unsigned seed = 32'h1badf00d;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) pcyc <= pcyc + 1;

  serial_audio_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .pin_fmt(pin_fmt), .reg_fmt(reg_fmt), .rj_len(rj_len), .pack_en(pack_en),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

  always @(negedge clk) begin
    bit e;
    if (armed) begin
      e = (q.size() > 0) && (q[0].cyc == pcyc);
      vectors++;
      if (e) begin
        if (pair_valid !== 1'b1 || left_out !== q[0].l || right_out !== q[0].r) begin
          miscompares++;
          $display("FAIL %s cyc %0d: valid=%b L=%h R=%h expected valid=1 L=%h R=%h",
                   q[0].tag, pcyc, pair_valid, left_out, right_out, q[0].l, q[0].r);
        end
        void'(q.pop_front());
      end else if (pair_valid !== 1'b0) begin
        miscompares++;
        $display("FAIL R9 cyc %0d: valid=%b L=%h R=%h expected valid=0",
                 pcyc, pair_valid, left_out, right_out);
      end
    end
  end

  function automatic logic [23:0] expw(logic [31:0] w, int W);
    if (W >= 24) return 24'(w >> (W - 24));
    return 24'(w << (24 - W));
  endfunction

  function automatic logic hbit(logic [31:0] w, int W, int p);
    if (p < 0 || p >= W) return 1'b0;
    return w[W-1-p];
  endfunction

  function automatic logic [31:0] rnd(int W);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return (W >= 32) ? seed : (seed & ((32'd1 << W) - 32'd1));
  endfunction

  task automatic slot(input logic lrv, input logic sdv, input bit push);
    exp_t x;
    logic launch;
    launch = (b_fmt == 3);
    lrclk = lrv; sdata = sdv; bclk = launch;
    repeat (H) @(posedge clk); #2;
    bclk = ~launch;
    if (push) begin
      x.cyc = pcyc + 2; x.l = pl; x.r = pr; x.tag = ptag;
      q.push_back(x);
    end
    repeat (H) @(posedge clk); #2;
  endtask

  task automatic send_half(input bit right, input logic [31:0] w, input int W,
                           input int half, input int pw, input bit fstart);
    for (int i = 0; i < half; i++) begin
      logic lrv;
      int p;
      if (b_fmt == 3) begin
        lrv = (i < pw); p = i - pw;
      end else begin
        lrv = (b_fmt == 1) ? right : ~right;
        p = (b_fmt == 1) ? i - 1 : (b_fmt == 0 && !b_pack) ? i - (half - W) : i;
      end
      slot(lrv, hbit(w, W, p), fstart && i == 0 && pend);
      if (fstart && i == 0) pend = 0;
    end
  endtask

  task automatic send_frame(input logic [31:0] L, input logic [31:0] R, input int W,
                            input int half, input int pw, input string tag);
    send_half(0, L, W, half, pw, 1);
    send_half(1, R, W, half, pw, 0);
    pend = 1; pl = expw(L, W); pr = expw(R, W); ptag = tag;
  endtask

  task automatic close_stream();
    slot((b_fmt == 3) ? 1'b1 : (b_fmt == 1 ? 1'b0 : 1'b1), 1'b0, pend);
    pend = 0;
  endtask

  task automatic preamble();
    for (int i = 0; i < 2; i++)
      slot((b_fmt == 3) ? 1'b0 : (b_fmt == 1 ? 1'b1 : 1'b0), 1'b0, 0);
  endtask

  task automatic setcfg(input logic [1:0] pf, input logic [1:0] rf, input logic [1:0] ln,
                        input logic pk, input int eff);
    pin_fmt = pf; reg_fmt = rf; rj_len = ln; pack_en = pk;
    b_fmt = eff; b_pack = pk; pend = 0;
    repeat (3) @(posedge clk); #2;
  endtask

  task automatic rnd_frames(input int n, input int W, input int half, input int pw,
                            input string tag);
    for (int i = 0; i < n; i++) send_frame(rnd(W), rnd(W), W, half, pw, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk); #2;
    vectors++;
    if (left_out !== 24'd0 || right_out !== 24'd0 || pair_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: L=%h R=%h valid=%b expected 0 0 0", left_out, right_out, pair_valid);
    end
    rst_n = 1'b1;
    @(posedge clk); #2;
    armed = 1;

    // R3 left-justified, full scale extremes
    setcfg(2'd2, 2'd0, 2'd0, 1'b0, 2);
    preamble();
    send_frame(32'h800000, 32'h7fffff, 24, 32, 0, "R3");
    send_frame(32'hffffff, 32'h000001, 24, 32, 0, "R3");
    rnd_frames(2, 24, 32, 0, "R3");
    // R8 overlong and short words in the same stream
    rnd_frames(2, 28, 32, 0, "R8");
    rnd_frames(2, 16, 32, 0, "R8");
    close_stream();

    // R4 I2S; pack_en must be ignored (R7)
    setcfg(2'd1, 2'd0, 2'd0, 1'b1, 1);
    preamble();
    rnd_frames(2, 24, 32, 0, "R4,R7");
    rnd_frames(2, 18, 32, 0, "R4");
    close_stream();

    // R5 right-justified, all length codes
    setcfg(2'd0, 2'd0, 2'd0, 1'b0, 0);
    preamble();
    rnd_frames(2, 24, 32, 0, "R5");
    close_stream();
    setcfg(2'd0, 2'd0, 2'd1, 1'b0, 0);
    preamble();
    rnd_frames(2, 20, 32, 0, "R5");
    close_stream();
    setcfg(2'd0, 2'd0, 2'd2, 1'b0, 0);
    preamble();
    rnd_frames(2, 16, 32, 0, "R5");
    close_stream();
    setcfg(2'd0, 2'd0, 2'd3, 1'b0, 0);
    preamble();
    rnd_frames(2, 24, 32, 0, "R5");
    close_stream();

    // R6 DSP pulse framing via register select
    setcfg(2'd0, 2'd3, 2'd0, 1'b0, 3);
    preamble();
    send_frame(32'h800000, 32'h7fffff, 24, 32, 1, "R6");
    rnd_frames(2, 24, 32, 1, "R6");
    close_stream();

    // R7 packed framing, left- and right-justified settings
    setcfg(2'd2, 2'd0, 2'd0, 1'b1, 2);
    preamble();
    rnd_frames(3, 16, 16, 0, "R7");
    close_stream();
    setcfg(2'd0, 2'd0, 2'd0, 1'b1, 0);
    preamble();
    rnd_frames(3, 16, 16, 0, "R7");
    close_stream();

    // R2 register overrides pins (pins ask for I2S, register for LJ)
    setcfg(2'd1, 2'd2, 2'd0, 1'b0, 2);
    preamble();
    rnd_frames(2, 24, 32, 0, "R2");
    close_stream();

    // R10 stream picked up mid left word: first frame must be dropped
    setcfg(2'd2, 2'd0, 2'd0, 1'b0, 2);
    send_frame(rnd(24), rnd(24), 24, 32, 0, "R10");
    pend = 0;
    rnd_frames(2, 24, 32, 0, "R10");
    close_stream();

    // R6 DSP with two-slot pulses and 20-bit words
    setcfg(2'd3, 2'd0, 2'd1, 1'b0, 3);
    preamble();
    rnd_frames(3, 20, 30, 2, "R6");
    close_stream();

    repeat (8) @(posedge clk); #2;
    while (q.size() > 0) begin
      miscompares++;
      $display("FAIL %s: pair L=%h R=%h never appeared, expected at cyc %0d",
               q[0].tag, q[0].l, q[0].r, q[0].cyc);
      void'(q.pop_front());
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run still busy at cyc %0d, expected completion", pcyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule